// File: doc/BRIEF.md
# Laser Motion Sensor Boot Sequencer

This block takes a laser motion sensor from reset to a running state. A pulse on `start` begins a fixed script. The script issues a soft reset command and waits a long settle time. It then reads five motion and delta registers and throws the data away, selects the 3K firmware mode, arms and starts the firmware download, and streams the firmware image over a raw SPI byte path. Last, it switches the laser on by reading its control register and writing the value back with the low nibble cleared. Register accesses go through a separate register access engine, which takes one command at a time and reports its completion with a one-cycle response. The sequencer never touches the SPI lines during those accesses.

The firmware image enters on a valid/ready byte stream. The sequencer asserts `fw_ready` only while the SPI byte path can take a byte and the minimum inter-byte gap has passed. An upstream source may therefore hold `fw_valid` for as long as it likes. Once `fw_valid` is high it must stay high with `fw_data` unchanged until a cycle in which `fw_ready` is also high. Any byte accepted from the stream is the byte handed to the SPI path in that same cycle. The block counts accepted bytes up to `FW_BYTES`. All waits are cycle counts set by parameters. By default they are derived from `CLK_HZ` as 50 ms, 10 ms and 15 µs.

Top module: `sensor_boot_seq`

## Requirements
- R1: After reset `busy`=0, `init_done`=0, `spi_cs_n`=1, and `reg_req_valid`, `spi_tx_valid` and `fw_ready` are all 0.
- R2: A `start` pulse seen while idle or done raises `busy` from the next cycle. `start` has no effect while `busy` is high. `busy` stays high until `init_done` rises, and `init_done` then holds at 1 with no further traffic until the next accepted `start`.
- R3: The first register command is a write (`reg_req_write`=1) of 0x5A to address 0x3A. The next command is accepted no sooner than `RESET_WAIT_CYC`+1 cycles after that write's response.
- R4: Next come five reads (`reg_req_write`=0) of addresses 0x02, 0x03, 0x04, 0x05 and 0x06, in that order. Their returned data has no effect on any later command.
- R5: Then 0x02 is written to 0x39 and 0x1D to 0x13. After the second write's response at least `FRAME_WAIT_CYC`+1 cycles pass before 0x18 is written to 0x13.
- R6: After the 0x18 write responds, `spi_cs_n` falls. The SPI path carries 0xE2 (load command 0x62 with bit 7 set) and then exactly `FW_BYTES` firmware bytes in stream order.
- R7: `spi_cs_n` stays low from the command byte until at least `BYTE_GAP_CYC` cycles after the last firmware byte. Consecutive SPI byte handshakes are at least `BYTE_GAP_CYC`+1 cycles apart.
- R8: At least `FRAME_WAIT_CYC`+1 cycles after `spi_cs_n` rises, address 0x20 is read, and the value read ANDed with 0xF0 is written to 0x20. That write's response completes the sequence.
- R9: A register command holds `reg_req_valid`, address, data and direction stable until `reg_req_ready`. No new command is issued before the response to the previous one, and none is issued while `spi_cs_n` is low.
- R10: `fw_ready` is high only while `spi_cs_n` is low and `spi_tx_ready` is high. Exactly `FW_BYTES` stream handshakes occur per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the boot script (idle or done only) |
| busy | output | 1 | Script in progress |
| init_done | output | 1 | Script finished, held until next start |
| reg_req_valid | output | 1 | Register command valid |
| reg_req_ready | input | 1 | Register engine accepts command |
| reg_req_write | output | 1 | 1 = write, 0 = read |
| reg_req_addr | output | 7 | Register address |
| reg_req_wdata | output | 8 | Write data |
| reg_rsp_valid | input | 1 | One-cycle completion of the outstanding command |
| reg_rsp_rdata | input | 8 | Read data, valid with reg_rsp_valid |
| spi_cs_n | output | 1 | Chip select for the burst, active low |
| spi_tx_valid | output | 1 | SPI byte valid |
| spi_tx_ready | input | 1 | SPI path takes the byte |
| spi_tx_data | output | 8 | SPI byte |
| fw_valid | input | 1 | Firmware stream byte valid |
| fw_ready | output | 1 | Firmware stream byte taken |
| fw_data | input | 8 | Firmware stream byte |

## Verification
The sequencer's outputs change one clock edge after the input that causes them. A `start` seen at an edge shows as `busy` at the next sample point. A response or SPI handshake at edge E loads a wait counter of W cycles, so the next command or byte becomes valid at edge E+W and can be accepted no sooner than E+W+1. The bench time-stamps every handshake with the edge at which it occurs. It checks each spacing as strictly greater than its wait parameter, and checks the chip-select release as at least the byte gap after the last byte. All outputs are sampled at the falling edge, half a period after the edge that set them.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    POST_NEXT,
    POST_LONG,
    POST_MID,
    POST_BURST
  } post_t;

  typedef struct packed {
    logic       wr;
    logic [6:0] addr;
    logic [7:0] data;
    post_t      post;
  } step_t;

  localparam int unsigned STEP_W      = 4;
  localparam int unsigned LAST_STEP   = 10;
  localparam int unsigned LASER_RD    = 9;
  localparam logic [7:0]  LOAD_CMD    = 8'hE2;

  function automatic step_t step_of(input logic [STEP_W-1:0] idx,
                                    input logic [7:0] laser_cur);
    step_t s;
    s = '{wr: 1'b0, addr: 7'h00, data: 8'h00, post: POST_NEXT};
    case (idx)
      4'd0:  s = '{wr: 1'b1, addr: 7'h3A, data: 8'h5A, post: POST_LONG};
      4'd1,
      4'd2,
      4'd3,
      4'd4,
      4'd5:  s = '{wr: 1'b0, addr: 7'(idx + 4'd1), data: 8'h00, post: POST_NEXT};
      4'd6:  s = '{wr: 1'b1, addr: 7'h39, data: 8'h02, post: POST_NEXT};
      4'd7:  s = '{wr: 1'b1, addr: 7'h13, data: 8'h1D, post: POST_MID};
      4'd8:  s = '{wr: 1'b1, addr: 7'h13, data: 8'h18, post: POST_BURST};
      4'd9:  s = '{wr: 1'b0, addr: 7'h20, data: 8'h00, post: POST_NEXT};
      4'd10: s = '{wr: 1'b1, addr: 7'h20, data: laser_cur & 8'hF0, post: POST_NEXT};
      default: s = '{wr: 1'b0, addr: 7'h00, data: 8'h00, post: POST_NEXT};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sbs_wait_timer.sv
module sbs_wait_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cycles,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= cycles;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/sbs_fw_burst.sv
module sbs_fw_burst
  import sbs_pkg::*;
#(
  parameter int unsigned FW_BYTES = 3070,
  parameter int unsigned GAP_CYC  = 750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  output logic       done,
  output logic       spi_cs_n,
  output logic       spi_tx_valid,
  input  logic       spi_tx_ready,
  output logic [7:0] spi_tx_data,
  input  logic       fw_valid,
  output logic       fw_ready,
  input  logic [7:0] fw_data
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam int unsigned NW = $clog2(FW_BYTES + 1);

  typedef enum logic [1:0] {B_IDLE, B_CMD, B_GAP, B_DATA} bst_t;
  bst_t          st;
  logic [NW-1:0] sent;
  logic          gap_exp;
  logic          accept;
  logic          all_sent;

  assign spi_cs_n     = (st == B_IDLE);
  assign spi_tx_valid = (st == B_CMD) || ((st == B_DATA) && fw_valid);
  assign spi_tx_data  = (st == B_CMD) ? LOAD_CMD : fw_data;
  assign fw_ready     = (st == B_DATA) && spi_tx_ready;
  assign accept       = spi_tx_valid && spi_tx_ready;
  assign all_sent     = (sent == NW'(FW_BYTES));
  assign done         = (st == B_GAP) && gap_exp && all_sent;

  sbs_wait_timer #(.CW(GW)) gap_tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .cycles (GW'(GAP_CYC)),
    .expire (gap_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= B_IDLE;
      sent <= '0;
    end else begin
      case (st)
        B_IDLE: if (go) begin
          st   <= B_CMD;
          sent <= '0;
        end
        B_CMD:  if (accept) st <= B_GAP;
        B_DATA: if (accept) begin
          st   <= B_GAP;
          sent <= sent + 1'b1;
        end
        B_GAP:  if (gap_exp) st <= all_sent ? B_IDLE : B_DATA;
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_boot_seq.sv
module sensor_boot_seq
  import sbs_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 50_000_000,
  parameter int unsigned RESET_WAIT_CYC = CLK_HZ / 20,
  parameter int unsigned FRAME_WAIT_CYC = CLK_HZ / 100,
  parameter int unsigned BYTE_GAP_CYC   = (CLK_HZ / 1_000_000) * 15,
  parameter int unsigned FW_BYTES       = 3070
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       init_done,
  output logic       reg_req_valid,
  input  logic       reg_req_ready,
  output logic       reg_req_write,
  output logic [6:0] reg_req_addr,
  output logic [7:0] reg_req_wdata,
  input  logic       reg_rsp_valid,
  input  logic [7:0] reg_rsp_rdata,
  output logic       spi_cs_n,
  output logic       spi_tx_valid,
  input  logic       spi_tx_ready,
  output logic [7:0] spi_tx_data,
  input  logic       fw_valid,
  output logic       fw_ready,
  input  logic [7:0] fw_data
);
  localparam int unsigned WAIT_MAX = (RESET_WAIT_CYC > FRAME_WAIT_CYC) ?
                                     RESET_WAIT_CYC : FRAME_WAIT_CYC;
  localparam int unsigned TW = $clog2(WAIT_MAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RSP, ST_WAIT, ST_BURST, ST_DONE} ph_t;
  ph_t               ph;
  logic [STEP_W-1:0] step;
  logic [7:0]        laser_cur;
  step_t             cur;
  logic              rsp_hit;
  logic              wait_load;
  logic [TW-1:0]     wait_cycles;
  logic              wait_exp;
  logic              burst_go;
  logic              burst_done;

  assign cur           = step_of(step, laser_cur);
  assign rsp_hit       = (ph == ST_RSP) && reg_rsp_valid;
  assign busy          = (ph != ST_IDLE) && (ph != ST_DONE);
  assign init_done     = (ph == ST_DONE);
  assign reg_req_valid = (ph == ST_REQ);
  assign reg_req_write = cur.wr;
  assign reg_req_addr  = cur.addr;
  assign reg_req_wdata = cur.data;
  assign burst_go      = rsp_hit && (cur.post == POST_BURST);
  assign wait_load     = (rsp_hit && ((cur.post == POST_LONG) || (cur.post == POST_MID)))
                       || ((ph == ST_BURST) && burst_done);
  assign wait_cycles   = (rsp_hit && (cur.post == POST_LONG)) ?
                         TW'(RESET_WAIT_CYC) : TW'(FRAME_WAIT_CYC);

  sbs_wait_timer #(.CW(TW)) step_tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wait_load),
    .cycles (wait_cycles),
    .expire (wait_exp)
  );

  sbs_fw_burst #(.FW_BYTES(FW_BYTES), .GAP_CYC(BYTE_GAP_CYC)) burst_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (burst_go),
    .done         (burst_done),
    .spi_cs_n     (spi_cs_n),
    .spi_tx_valid (spi_tx_valid),
    .spi_tx_ready (spi_tx_ready),
    .spi_tx_data  (spi_tx_data),
    .fw_valid     (fw_valid),
    .fw_ready     (fw_ready),
    .fw_data      (fw_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= ST_IDLE;
      step      <= '0;
      laser_cur <= '0;
    end else begin
      case (ph)
        ST_IDLE, ST_DONE: if (start) begin
          ph   <= ST_REQ;
          step <= '0;
        end
        ST_REQ: if (reg_req_ready) ph <= ST_RSP;
        ST_RSP: if (reg_rsp_valid) begin
          if (step == STEP_W'(LASER_RD)) laser_cur <= reg_rsp_rdata;
          case (cur.post)
            POST_NEXT: begin
              if (step == STEP_W'(LAST_STEP)) ph <= ST_DONE;
              else begin
                step <= step + 1'b1;
                ph   <= ST_REQ;
              end
            end
            POST_BURST: ph <= ST_BURST;
            default:    ph <= ST_WAIT;
          endcase
        end
        ST_WAIT: if (wait_exp) begin
          step <= step + 1'b1;
          ph   <= ST_REQ;
        end
        ST_BURST: if (burst_done) ph <= ST_WAIT;
        default: ph <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned GAP_CYC = 750
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       init_done,
  input logic       reg_req_valid,
  input logic       reg_req_ready,
  input logic       reg_req_write,
  input logic [6:0] reg_req_addr,
  input logic [7:0] reg_req_wdata,
  input logic       reg_rsp_valid,
  input logic       spi_cs_n,
  input logic       spi_tx_valid,
  input logic       spi_tx_ready,
  input logic       fw_ready
);
  logic        outstanding;
  logic        armed;
  logic [31:0] since_tx;
  logic        tx_hs;

  assign tx_hs = spi_tx_valid && spi_tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      armed       <= 1'b0;
      since_tx    <= '0;
    end else begin
      if (reg_req_valid && reg_req_ready) outstanding <= 1'b1;
      else if (reg_rsp_valid)             outstanding <= 1'b0;
      if (tx_hs) begin
        armed    <= 1'b1;
        since_tx <= '0;
      end else begin
        if (spi_cs_n) armed <= 1'b0;
        if (since_tx != 32'hFFFF_FFFF) since_tx <= since_tx + 1'b1;
      end
    end
  end

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=> reg_req_valid &&
      $stable({reg_req_write, reg_req_addr, reg_req_wdata}));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !reg_req_valid);

  a_r9_no_reg_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !reg_req_valid);

  a_r7_tx_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> !spi_cs_n);

  a_r7_byte_gap: assert property (@(posedge clk) disable iff (!rst_n)
    armed && tx_hs |-> since_tx >= GAP_CYC);

  a_r10_fw_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fw_ready |-> !spi_cs_n && spi_tx_ready);

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !busy);

  a_r2_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> init_done);
endmodule

bind sensor_boot_seq sbs_checker #(.GAP_CYC(BYTE_GAP_CYC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .init_done     (init_done),
  .reg_req_valid (reg_req_valid),
  .reg_req_ready (reg_req_ready),
  .reg_req_write (reg_req_write),
  .reg_req_addr  (reg_req_addr),
  .reg_req_wdata (reg_req_wdata),
  .reg_rsp_valid (reg_rsp_valid),
  .spi_cs_n      (spi_cs_n),
  .spi_tx_valid  (spi_tx_valid),
  .spi_tx_ready  (spi_tx_ready),
  .fw_ready      (fw_ready)
);

// File: tb/sensor_boot_seq_tb_top.sv
module sensor_boot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_W      = 40;
  localparam int FRM_W      = 20;
  localparam int GAP_W      = 5;
  localparam int FW_N       = 12;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, init_done;
  logic       reg_req_valid, reg_req_write;
  logic       reg_req_ready = 1'b0;
  logic [6:0] reg_req_addr;
  logic [7:0] reg_req_wdata;
  logic       reg_rsp_valid = 1'b0;
  logic [7:0] reg_rsp_rdata = 8'h00;
  logic       spi_cs_n, spi_tx_valid;
  logic       spi_tx_ready = 1'b0;
  logic [7:0] spi_tx_data;
  logic       fw_valid = 1'b0;
  logic       fw_ready;
  logic [7:0] fw_data = 8'h00;

  sensor_boot_seq #(
    .RESET_WAIT_CYC (RST_W),
    .FRAME_WAIT_CYC (FRM_W),
    .BYTE_GAP_CYC   (GAP_W),
    .FW_BYTES       (FW_N)
  ) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  bit         op_wr[32];
  logic [6:0] op_addr[32];
  logic [7:0] op_data[32];
  int         op_acc[32];
  int         op_rsp[32];
  int         op_n = 0;
  bit         reg_in_burst = 0;

  logic [7:0] by_data[64];
  int         by_cyc[64];
  bit         by_cs[64];
  int         by_n = 0;
  int         cs_rise = 0;
  int         fw_hs = 0;
  int         fw_ready_bad = 0;

  logic [7:0] fw_mem[64];
  int         fw_idx = 0;
  logic [7:0] laser_val = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_wr(input int i);
    return (i == 0) || (i >= 6 && i <= 8) || (i == 10);
  endfunction

  function automatic logic [6:0] exp_addr(input int i);
    case (i)
      0: return 7'h3A;
      1, 2, 3, 4, 5: return 7'(i + 1);
      6: return 7'h39;
      7, 8: return 7'h13;
      default: return 7'h20;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int i, input logic [7:0] lz);
    case (i)
      0: return 8'h5A;
      6: return 8'h02;
      7: return 8'h1D;
      8: return 8'h18;
      10: return lz & 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string op_req(input int i);
    if (i == 0) return "R3";
    if (i <= 5) return "R4";
    if (i <= 8) return "R5";
    return "R8";
  endfunction

  initial forever @(posedge clk) cyc++;

  // register engine model
  initial begin
    bit pend = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (reg_rsp_valid) reg_rsp_valid = 1'b0;
      if (reg_req_ready) begin
        reg_req_ready = 1'b0;
        pend = 1;
        dly = $urandom % 3;
      end else if (pend) begin
        if (dly == 0) begin
          reg_rsp_valid = 1'b1;
          reg_rsp_rdata = (!op_wr[op_n-1] && op_addr[op_n-1] == 7'h20) ?
                          laser_val : 8'($urandom);
          op_rsp[op_n-1] = cyc + 1;
          pend = 0;
        end else dly--;
      end else if (reg_req_valid && ($urandom % 2 == 0)) begin
        reg_req_ready = 1'b1;
        if (op_n < 32) begin
          op_wr[op_n]   = reg_req_write;
          op_addr[op_n] = reg_req_addr;
          op_data[op_n] = reg_req_wdata;
          op_acc[op_n]  = cyc + 1;
        end
        op_n++;
        if (!spi_cs_n) reg_in_burst = 1;
      end
    end
  end

  // SPI sink and firmware source
  initial begin
    bit acc_pend = 0;
    bit acc_fw = 0;
    bit prev_cs = 1;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (spi_cs_n && !prev_cs) cs_rise = cyc;
      prev_cs = spi_cs_n;
      if (acc_pend) begin
        acc_pend = 0;
        spi_tx_ready = 1'b0;
        if (acc_fw) begin
          fw_idx++;
          fw_valid = 1'b0;
        end
      end else begin
        if (!fw_valid && fw_idx < FW_N && ($urandom % 3 != 0)) begin
          fw_valid = 1'b1;
          fw_data  = fw_mem[fw_idx];
        end
        #1;
        if (spi_tx_valid && ($urandom % 3 != 0)) begin
          spi_tx_ready = 1'b1;
          acc_pend = 1;
          acc_fw = (by_n > 0);
          if (by_n < 64) begin
            by_data[by_n] = spi_tx_data;
            by_cyc[by_n]  = cyc + 1;
            by_cs[by_n]   = !spi_cs_n;
          end
          by_n++;
          #1;
          if (fw_ready && fw_valid) fw_hs++;
        end
      end
      #1;
      if (fw_ready && !spi_tx_ready) fw_ready_bad++;
    end
  end

  task automatic run_once(input bit poke_start);
    op_n = 0; by_n = 0; fw_idx = 0; fw_hs = 0; fw_ready_bad = 0;
    reg_in_burst = 0;
    for (int i = 0; i < FW_N; i++) fw_mem[i] = 8'($urandom);
    fw_mem[0] = 8'h00;
    fw_mem[FW_N-1] = 8'hFF;
    laser_val = 8'($urandom) | 8'h0F;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    check(init_done === 1'b0, "R2", "done cleared by start", int'(init_done), 0);
    if (poke_start) begin
      while (by_n < 3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!init_done) @(negedge clk);
    repeat (15) @(negedge clk);
    check(init_done === 1'b1 && busy === 1'b0, "R2", "done held",
          int'({init_done, busy}), 2);
    check(op_n == 11, "R2", "register command count", op_n, 11);
    for (int i = 0; i < 11; i++) begin
      logic [15:0] act, exp;
      act = {op_wr[i], op_addr[i], op_wr[i] ? op_data[i] : 8'h00};
      exp = {exp_wr(i), exp_addr(i), exp_wr(i) ? exp_data(i, laser_val) : 8'h00};
      check(act == exp, op_req(i), $sformatf("command %0d", i), int'(act), int'(exp));
    end
    check(op_acc[1] - op_rsp[0] > RST_W, "R3", "reset settle cycles",
          op_acc[1] - op_rsp[0], RST_W + 1);
    check(op_acc[8] - op_rsp[7] > FRM_W, "R5", "frame wait cycles",
          op_acc[8] - op_rsp[7], FRM_W + 1);
    check(by_n == FW_N + 1, "R6", "SPI byte count", by_n, FW_N + 1);
    check(by_data[0] == 8'hE2, "R6", "load command byte", int'(by_data[0]), 8'hE2);
    check(by_cyc[0] > op_rsp[8], "R6", "burst after download write",
          by_cyc[0], op_rsp[8] + 1);
    for (int i = 1; i <= FW_N; i++) begin
      check(by_data[i] == fw_mem[i-1], "R6", $sformatf("fw byte %0d", i-1),
            int'(by_data[i]), int'(fw_mem[i-1]));
      check(by_cyc[i] - by_cyc[i-1] > GAP_W, "R7", $sformatf("gap before byte %0d", i),
            by_cyc[i] - by_cyc[i-1], GAP_W + 1);
    end
    for (int i = 0; i <= FW_N; i++)
      check(by_cs[i], "R7", $sformatf("cs low at byte %0d", i), int'(by_cs[i]), 1);
    check(cs_rise - by_cyc[FW_N] >= GAP_W, "R7", "cs hold after last byte",
          cs_rise - by_cyc[FW_N], GAP_W);
    check(op_acc[9] - cs_rise > FRM_W, "R8", "wait before laser read",
          op_acc[9] - cs_rise, FRM_W + 1);
    check(!reg_in_burst, "R9", "register command during burst", int'(reg_in_burst), 0);
    check(fw_hs == FW_N, "R10", "stream handshakes", fw_hs, FW_N);
    check(fw_ready_bad == 0, "R10", "fw_ready without SPI ready", fw_ready_bad, 0);
    check(spi_cs_n === 1'b1 && reg_req_valid === 1'b0, "R2", "quiet when done",
          int'({spi_cs_n, reg_req_valid}), 2);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && init_done === 1'b0, "R1", "status after reset",
          int'({busy, init_done}), 0);
    check(spi_cs_n === 1'b1, "R1", "cs after reset", int'(spi_cs_n), 1);
    check(reg_req_valid === 1'b0 && spi_tx_valid === 1'b0 && fw_ready === 1'b0,
          "R1", "valids after reset", int'({reg_req_valid, spi_tx_valid, fw_ready}), 0);
    run_once(1'b1);
    run_once(1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule